// File: doc/BRIEF.md
# Prescaled Countdown Timer

A free-standing down-counter that runs off the core clock and is driven through four word-wide registers: control, live count, period and scale. A prescaler divides the clock by the scale value plus one. Each prescaler tick lowers the live count by one. When the count steps from one to zero, a sticky interrupt flag is set. The counter then either reloads from the period register and keeps running, or parks at zero until software writes a new count.

Software typically loads an initial count and a period, sets the power and enable bits, and then either waits for the interrupt or polls the live count until it reads zero. The first interval comes from the count register. Every later interval comes from the period register. The flag stays high until software acknowledges it by writing a one to the flag bit.

Top module: `pscl_countdown_timer`

## Requirements
- R1: After reset every register reads zero, the live count is zero and `irq` is low.
- R2: Registers are selected by address: 0 control, 1 live count, 2 period, 3 scale.
  - Control reads back power in bit 0, enable in bit 1, auto-reload in bit 2 and the interrupt flag in bit 3, with all higher bits zero.
  - Period is 32 bits wide. Scale is 8 bits wide and its upper bits read zero.
- R3: The count changes only when both power (bit 0) and enable (bit 1) are set, or when software writes it. Otherwise it holds.
- R4: With scale N, the count drops by exactly one once every N+1 clocks. The prescaler is cleared while the timer is stopped, so after the enabling write the first decrement comes N+1 clocks after the edge that takes the write.
- R5: When a decrement takes the count from 1 to 0, the flag (control bit 3) is set and `irq` goes high on the same edge.
- R6: With auto-reload (bit 2) set, the expiring tick loads the period value into the count instead of zero, and counting goes on.
- R7: With auto-reload clear, the count stays at zero after expiry and no further flag is raised while it sits at zero.
- R8: The flag is sticky. It is cleared only by a control write with bit 3 set, and a control write with bit 3 clear leaves it alone. If an expiry and a clearing write fall on the same edge, the flag stays set.
- R9: A write to the live count takes effect on the next edge, even while running, and wins over a tick on that edge. That tick raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench goes after the edges of the first interval:
- A prescaler that is not cleared on stop makes the first decrement after re-enabling arrive early.
- An off-by-one divider shifts every decrement.

In auto-reload mode, a design that reloaded a cycle late, or loaded zero, shows a wrong count right after expiry. A design that let the clearing write beat a simultaneous expiry would lose an interrupt. A design that let a tick beat a count write would show a count one below the written value. The bench also checks that one-shot mode parks at zero and stays quiet after acknowledge, and that writing zero to the flag bit does not clear it.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_SCALE  = 2'd3
  } reg_sel_e;

  localparam int CB_POWER  = 0;
  localparam int CB_ENABLE = 1;
  localparam int CB_RELOAD = 2;
  localparam int CB_FLAG   = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic reload;
    logic enable;
    logic power;
  } ctrl_t;
endpackage

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               expire,
  output ctrl_t              ctrl,
  output logic               flag,
  output logic [CNT_W-1:0]   period,
  output logic [SCALE_W-1:0] scale,
  output logic               cnt_load,
  output logic [CNT_W-1:0]   cnt_load_val
);
  reg_sel_e           sel;
  logic               wr_ctrl, wr_period, wr_scale;
  ctrl_t              ctrl_q, ctrl_d;
  logic               flag_q, flag_d;
  logic [CNT_W-1:0]   period_q, period_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic               unused_wr;

  assign unused_wr = ^wr_data;
  assign sel       = reg_sel_e'(wr_addr);
  assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
  assign wr_period = wr_en && (sel == SEL_PERIOD);
  assign wr_scale  = wr_en && (sel == SEL_SCALE);

  always_comb begin
    ctrl_d   = ctrl_q;
    flag_d   = flag_q;
    period_d = period_q;
    scale_d  = scale_q;
    if (wr_ctrl) begin
      ctrl_d.power  = wr_data[CB_POWER];
      ctrl_d.enable = wr_data[CB_ENABLE];
      ctrl_d.reload = wr_data[CB_RELOAD];
      if (wr_data[CB_FLAG]) flag_d = 1'b0;
    end
    // a new expiry outranks a clearing write on the same edge
    if (expire)    flag_d   = 1'b1;
    if (wr_period) period_d = wr_data[CNT_W-1:0];
    if (wr_scale)  scale_d  = wr_data[SCALE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
      period_q <= period_d;
      scale_q  <= scale_d;
    end
  end

  assign ctrl         = ctrl_q;
  assign flag         = flag_q;
  assign period       = period_q;
  assign scale        = scale_q;
  assign cnt_load     = wr_en && (sel == SEL_COUNT);
  assign cnt_load_val = wr_data[CNT_W-1:0];
endmodule

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
module cdt_prescale #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick,
  output logic [SCALE_W-1:0] phase
);
  logic [SCALE_W-1:0] phase_q, phase_d;

  // >= keeps the divider sane if scale is lowered below the current phase
  assign tick = run && (phase_q >= scale);

  always_comb begin
    if (!run || tick) phase_d = '0;
    else              phase_d = phase_q + SCALE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             at_one, at_zero;

  assign at_one  = (count_q == CNT_W'(1));
  assign at_zero = (count_q == '0);
  assign expire  = tick && at_one && !load;

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = load_val;
    end else if (tick && !at_zero) begin
      if (at_one) count_d = reload_en ? period : '0;
      else        count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/pscl_countdown_timer.sv
`timescale 1ns/1ps
module pscl_countdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SCALE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  ctrl_t              ctrl;
  logic               flag;
  logic [CNT_W-1:0]   period_q;
  logic [SCALE_W-1:0] scale_q;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_load_val;
  logic               run;
  logic               tick;
  logic [SCALE_W-1:0] phase;
  logic [CNT_W-1:0]   count_q;
  logic               expire;

  cdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .expire(expire), .ctrl(ctrl), .flag(flag),
    .period(period_q), .scale(scale_q), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val)
  );

  assign run = ctrl.power && ctrl.enable;

  cdt_prescale #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .scale(scale_q),
    .tick(tick), .phase(phase)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(cnt_load_val), .reload_en(ctrl.reload), .period(period_q),
    .count(count_q), .expire(expire)
  );

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      SEL_CTRL:   rd_data = DATA_W'({flag, ctrl.reload, ctrl.enable, ctrl.power});
      SEL_COUNT:  rd_data = DATA_W'(count_q);
      SEL_PERIOD: rd_data = DATA_W'(period_q);
      SEL_SCALE:  rd_data = DATA_W'(scale_q);
      default:    rd_data = '0;
    endcase
  end

  assign irq = flag;
endmodule

// File: rtl/cdt_checker.sv
`timescale 1ns/1ps
module cdt_checker #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SCALE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               irq,
  input logic               run,
  input logic               tick,
  input logic               reload,
  input logic [SCALE_W-1:0] phase,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   period,
  input logic               expire
);
  logic load, ack;
  assign load = wr_en && (wr_addr == 2'd1);
  assign ack  = wr_en && (wr_addr == 2'd0) && wr_data[3];

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));  // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count > CNT_W'(1) && !load) |=> count == $past(count) - CNT_W'(1));  // R4
  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase == '0);  // R4
  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);  // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> count == $past(period));  // R6
  AST_ZERO_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);  // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(wr_data[CNT_W-1:0]));  // R9
endmodule

bind pscl_countdown_timer cdt_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .run(run), .tick(tick),
  .reload(ctrl.reload), .phase(phase), .count(count_q),
  .period(period_q), .expire(expire)
);

// File: tb/sim_pscl_countdown_timer.sv
`timescale 1ns/1ps
module sim_pscl_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pscl_countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cnt(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(2'd1, v); chk(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 register zero after reset", v, 0);
    end
    chk("R1 irq low after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(2'd2, 32'h0001_2345);
    wr(2'd3, 32'h0000_01A5);
    rd(2'd2, v); chk("R2 period readback", v, 32'h0001_2345);
    rd(2'd3, v); chk("R2 scale readback 8 bits", v, 32'h0000_00A5);
    wr(2'd0, 32'hFFFF_FFF4);
    rd(2'd0, v); chk("R2 control readback upper bits zero", v, 32'h4);
    wr(2'd0, 0); wr(2'd3, 0); wr(2'd2, 0);
  endtask

  task automatic t_gate;
    wr(2'd1, 10);
    wr(2'd0, 1); idle(5); chk_cnt("R3 power only holds", 10);
    wr(2'd0, 2); idle(5); chk_cnt("R3 enable only holds", 10);
    wr(2'd0, 3); chk_cnt("R3 no step on enabling edge", 10);
    idle(4); chk_cnt("R3 runs when both set", 6);
    wr(2'd0, 0); chk_cnt("R3 last step on stopping edge", 5);
    idle(5); chk_cnt("R3 frozen after stop", 5);
  endtask

  task automatic t_scale;
    wr(2'd3, 2); wr(2'd1, 20); wr(2'd0, 3);
    idle(2); chk_cnt("R4 no step before scale+1", 20);
    idle(1); chk_cnt("R4 first step at scale+1", 19);
    idle(3); chk_cnt("R4 second step", 18);
    idle(1); wr(2'd0, 0); wr(2'd0, 3);
    idle(2); chk_cnt("R4 prescaler cleared on stop", 18);
    idle(1); chk_cnt("R4 full interval after re-enable", 17);
    wr(2'd0, 0); wr(2'd3, 0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(2'd0, 8); wr(2'd2, 4); wr(2'd1, 3); wr(2'd0, 7);
    chk_cnt("R6 start", 3);
    idle(1); chk_cnt("R6 step", 2);
    idle(1); chk_cnt("R5 one before expiry", 1);
    chk("R5 irq low before expiry", {31'b0, irq}, 0);
    idle(1); chk_cnt("R6 reload from period", 4);
    chk("R5 irq on expiry", {31'b0, irq}, 1);
    rd(2'd0, v); chk("R5 flag bit 3 set", v, 32'hF);
    wr(2'd0, 7); chk("R8 zero in flag bit keeps flag", {31'b0, irq}, 1);
    wr(2'd0, 32'hF); chk("R8 ack clears flag", {31'b0, irq}, 0);
    chk_cnt("R6 counting on", 2);
    idle(2); chk_cnt("R6 second reload", 4);
    chk("R5 second expiry", {31'b0, irq}, 1);
    wr(2'd0, 32'hF); chk("R8 ack again", {31'b0, irq}, 0);
    idle(2); chk_cnt("R8 about to expire", 1);
    wr(2'd0, 32'hF); chk("R8 expiry beats ack", {31'b0, irq}, 1);
    wr(2'd0, 8);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(2'd1, 2); wr(2'd0, 3);
    chk_cnt("R7 start", 2);
    idle(2); chk_cnt("R7 parks at zero", 0);
    chk("R7 flag on one-shot expiry", {31'b0, irq}, 1);
    wr(2'd0, 32'hB); chk("R7 ack", {31'b0, irq}, 0);
    idle(5); chk_cnt("R7 stays at zero", 0);
    chk("R7 no new flag at zero", {31'b0, irq}, 0);
    rd(2'd0, v); chk("R7 control after ack", v, 32'h3);
    wr(2'd0, 0);
  endtask

  task automatic t_override;
    wr(2'd1, 100); wr(2'd0, 3);
    idle(3); chk_cnt("R9 running", 97);
    wr(2'd1, 50); chk_cnt("R9 write wins over tick", 50);
    idle(2); chk_cnt("R9 counts from written value", 48);
    wr(2'd1, 1); chk_cnt("R9 load of one", 1);
    wr(2'd1, 9); chk_cnt("R9 load beats expiry", 9);
    chk("R9 no flag when load beats expiry", {31'b0, irq}, 0);
    wr(2'd0, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regs();
    t_gate();
    t_scale();
    t_reload();
    t_oneshot();
    t_override();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule